// File: doc/BRIEF.md
# Backup Supply Switch-Over Controller

This block is the digital half of a backup supply arrangement. Analog comparators, which sit outside it, report three conditions as logic levels: the main supply is above the battery, the main supply is above the switch-over threshold, and the battery is below its low-voltage limit. The block synchronizes these levels, decides which supply feeds the internal rail, and keeps two status flags.

The switch flag records that the rail moved to the battery and stays set until software clears it with a strobe. The low-battery flag tracks the comparator and cannot be cleared by software; it drops by itself once the battery recovers. Each flag has an enable, and an enabled flag pulls the active-low interrupt output low. A 2-bit mode input selects one of three policies: threshold-qualified switching, direct comparison, or no switching at all.

Top module: `bkup_supply_ctrl`

## Requirements
- R1: In standard mode (mode_i = 2'b00) the battery is selected (sel_batt_o = 1) only when the main supply is neither above the battery nor above the switch-over threshold; otherwise the main supply is selected.
- R2: In direct mode (mode_i = 2'b01) the battery is selected exactly when the main supply is not above the battery, whatever the threshold comparison says.
- R3: In disabled mode (mode_i = 2'b10 or 2'b11) the main supply is always selected and bsf_o reads 0.
- R4: bsf_o goes to 1 on the cycle in which selection changes from the main supply to the battery, and then holds until a one-cycle pulse on bsf_clr_i clears it.
- R5: A clear pulse that coincides with a new switch-to-battery event leaves bsf_o at 1.
- R6: blf_o follows the synchronized low-battery comparator, including while the battery is selected. bsf_clr_i has no effect on it.
- R7: irq_no is active low and is asserted when (bsf_o AND bsf_ie_i) OR (blf_o AND blf_ie_i). It releases in the same cycle that an enable drops or a flag clears.
- R8: A comparator change shows on sel_batt_o, bsf_o and blf_o after the third rising clock edge that follows it. Two of these edges are synchronizer stages and the third is the output register.
- R9: During and after reset, with no edge since, sel_batt_o, bsf_o and blf_o are 0 and irq_no is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vdd_gt_vbat_i | input | 1 | Comparator: main supply above battery |
| vdd_gt_vth_i | input | 1 | Comparator: main supply above switch-over threshold |
| vbat_low_i | input | 1 | Comparator: battery below low limit |
| mode_i | input | 2 | 00 standard, 01 direct, 1x switching disabled |
| bsf_ie_i | input | 1 | Interrupt enable for the switch flag |
| blf_ie_i | input | 1 | Interrupt enable for the low-battery flag |
| bsf_clr_i | input | 1 | One-cycle software clear of the switch flag |
| sel_batt_o | output | 1 | 1 selects the battery, 0 the main supply |
| bsf_o | output | 1 | Battery switch flag |
| blf_o | output | 1 | Battery low flag |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
A software clear of the switch flag can arrive on the same edge at which a new switch to the battery sets that flag. The bench creates this case by counting synchronizer edges from a comparator change, so that the clear pulse lands on the third edge, the one where the flag is set. The set must win, and bsf_o must read 1. A second clear, sent while the battery stays selected, must then clear the flag without setting it again.

// File: rtl/bkup_pkg.sv
package bkup_pkg;
  typedef enum logic [1:0] {
    MODE_STD    = 2'b00,
    MODE_DIRECT = 2'b01,
    MODE_OFF    = 2'b10,
    MODE_OFF_B  = 2'b11
  } sw_mode_e;

  localparam int unsigned CMP_W = 3;
  localparam int unsigned CMP_GT_VBAT = 0;
  localparam int unsigned CMP_GT_VTH  = 1;
  localparam int unsigned CMP_LOW     = 2;

  function automatic logic mode_off(sw_mode_e m);
    return m[1];
  endfunction
endpackage

// File: rtl/bkup_sync.sv
module bkup_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[s] <= '0;
      else if (s == 0) pipe_q[s] <= d_i;
      else pipe_q[s] <= pipe_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/bkup_select.sv
module bkup_select
  import bkup_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     gt_vbat_i,
  input  logic     gt_vth_i,
  input  sw_mode_e mode_i,
  output logic     sel_batt_o,
  output logic     to_batt_o
);
  logic sel_d, sel_q;

  always_comb begin
    unique case (mode_i)
      MODE_STD:    sel_d = !gt_vbat_i && !gt_vth_i;
      MODE_DIRECT: sel_d = !gt_vbat_i;
      default:     sel_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= 1'b0;
    else         sel_q <= sel_d;
  end

  assign sel_batt_o = sel_q;
  assign to_batt_o  = sel_d && !sel_q;

  AST_STD_THRESH_KEEPS_VDD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_STD && gt_vth_i) |=> !sel_q); // R1
  AST_DIRECT_FOLLOWS_CMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_DIRECT) |=> (sel_q == !$past(gt_vbat_i))); // R2
  AST_OFF_NO_BATT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_off(mode_i) |=> !sel_q); // R3
endmodule

// File: rtl/bkup_flags.sv
module bkup_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic to_batt_i,
  input  logic off_i,
  input  logic clr_i,
  input  logic low_i,
  output logic bsf_o,
  output logic blf_o
);
  logic bsf_q, blf_q;

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        bsf_q <= 1'b0;
    else if (off_i)     bsf_q <= 1'b0;
    else if (to_batt_i) bsf_q <= 1'b1;
    else if (clr_i)     bsf_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) blf_q <= 1'b0;
    else         blf_q <= low_i;
  end

  assign bsf_o = bsf_q;
  assign blf_o = blf_q;

  AST_BSF_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bsf_q && !clr_i && !off_i) |=> bsf_q); // R4
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (to_batt_i && clr_i && !off_i) |=> bsf_q); // R5
  AST_BLF_IGNORES_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && low_i) |=> blf_q); // R6
endmodule

// File: rtl/bkup_supply_ctrl.sv
module bkup_supply_ctrl
  import bkup_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       vdd_gt_vbat_i,
  input  logic       vdd_gt_vth_i,
  input  logic       vbat_low_i,
  input  logic [1:0] mode_i,
  input  logic       bsf_ie_i,
  input  logic       blf_ie_i,
  input  logic       bsf_clr_i,
  output logic       sel_batt_o,
  output logic       bsf_o,
  output logic       blf_o,
  output logic       irq_no
);
  logic [CMP_W-1:0] cmp_raw, cmp_s;
  logic to_batt;
  sw_mode_e mode;

  assign mode = sw_mode_e'(mode_i);
  assign cmp_raw[CMP_GT_VBAT] = vdd_gt_vbat_i;
  assign cmp_raw[CMP_GT_VTH]  = vdd_gt_vth_i;
  assign cmp_raw[CMP_LOW]     = vbat_low_i;

  bkup_sync #(.W(CMP_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cmp_raw), .q_o(cmp_s)
  );

  bkup_select u_sel (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .gt_vbat_i(cmp_s[CMP_GT_VBAT]), .gt_vth_i(cmp_s[CMP_GT_VTH]),
    .mode_i(mode), .sel_batt_o(sel_batt_o), .to_batt_o(to_batt)
  );

  bkup_flags u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .to_batt_i(to_batt),
    .off_i(mode_off(mode)), .clr_i(bsf_clr_i), .low_i(cmp_s[CMP_LOW]),
    .bsf_o(bsf_o), .blf_o(blf_o)
  );

  assign irq_no = !((bsf_o && bsf_ie_i) || (blf_o && blf_ie_i));

  AST_SWITCH_SETS_BSF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sel_batt_o) && !mode_off($past(mode))) |-> bsf_o); // R4
  AST_OFF_BSF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_off(mode) |=> !bsf_o); // R3
  AST_BLF_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blf_o && blf_ie_i) |-> !irq_no); // R7
endmodule

// File: tb/bkup_supply_ctrl_tb.sv
module bkup_supply_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic gt_vbat = 1'b0, gt_vth = 1'b0, low = 1'b0;
  logic [1:0] mode = 2'b00;
  logic bsie = 1'b0, blie = 1'b0, clr = 1'b0;
  logic sel, bsf, blf, irq_n;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  bkup_supply_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .vdd_gt_vbat_i(gt_vbat), .vdd_gt_vth_i(gt_vth),
    .vbat_low_i(low), .mode_i(mode), .bsf_ie_i(bsie), .blf_ie_i(blie),
    .bsf_clr_i(clr), .sel_batt_o(sel), .bsf_o(bsf), .blf_o(blf), .irq_no(irq_n)
  );

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic edge_n(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic settle();
    edge_n(3);
  endtask

  task automatic pulse_clr();
    clr = 1'b1;
    edge_n(1);
    clr = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    edge_n(2);
    check("R9 sel", sel, 1'b0);
    check("R9 bsf", bsf, 1'b0);
    check("R9 blf", blf, 1'b0);
    check("R9 irq", irq_n, 1'b1);
    rst_n = 1'b1;
    edge_n(1);

    // sweep modes and comparator combinations (R1 R2 R3 R4 R7)
    bsie = 1'b1;
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < 4; c++) begin
        logic a, b, exp_b;
        a = c[0]; b = c[1];
        mode = m[1:0];
        gt_vbat = 1'b1; gt_vth = 1'b1;
        settle();
        pulse_clr();
        check("R4 cleared", bsf, 1'b0);
        gt_vbat = a; gt_vth = b;
        settle();
        case (m)
          0: exp_b = !a && !b;
          1: exp_b = !a;
          default: exp_b = 1'b0;
        endcase
        check(m == 0 ? "R1 sel" : (m == 1 ? "R2 sel" : "R3 sel"), sel, exp_b);
        check(m >= 2 ? "R3 bsf" : "R4 bsf", bsf, exp_b);
        check("R7 irq bsf", irq_n, !exp_b);
        edge_n(4);
        check("R4 hold", bsf, exp_b);
      end
    end

    // R7 enable drop releases irq
    mode = 2'b00; gt_vbat = 1'b0; gt_vth = 1'b0;
    settle();
    bsie = 1'b0; #1;
    check("R7 bsie off", irq_n, 1'b1);
    bsie = 1'b1; #1;
    check("R7 bsie on", irq_n, 1'b0);

    // R8 latency and R5 coincidence
    gt_vbat = 1'b1; gt_vth = 1'b1;
    settle();
    pulse_clr();
    gt_vbat = 1'b0; gt_vth = 1'b0;
    edge_n(2);
    check("R8 not yet", sel, 1'b0);
    clr = 1'b1;
    edge_n(1);
    clr = 1'b0;
    check("R8 sel at third edge", sel, 1'b1);
    check("R5 set wins", bsf, 1'b1);
    pulse_clr();
    check("R4 clear on battery", bsf, 1'b0);
    check("R4 still battery", sel, 1'b1);
    edge_n(3);
    check("R4 no re-set", bsf, 1'b0);

    // R6 low battery while on battery
    bsie = 1'b0; blie = 1'b1;
    low = 1'b1;
    edge_n(2);
    check("R8 blf not yet", blf, 1'b0);
    edge_n(1);
    check("R6 blf set", blf, 1'b1);
    check("R7 irq blf", irq_n, 1'b0);
    pulse_clr();
    edge_n(2);
    check("R6 clr ignored", blf, 1'b1);
    blie = 1'b0; #1;
    check("R7 blie off", irq_n, 1'b1);
    blie = 1'b1;
    low = 1'b0;
    settle();
    check("R6 blf self clear", blf, 1'b0);
    check("R7 irq released", irq_n, 1'b1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule